// File: doc/BRIEF.md
# Pin-Level Asynchronous Serial Receiver

This block is the receive engine of a configurable I/O pin. Three registers shape it. The mode register holds a 5-bit function selector and a 2-bit pad-control field. The X register holds the bit timing and the character length. The result register Z holds the last character received. The engine runs only when the selector holds the receive code. It watches the pad for a falling edge on the idle-high line and confirms the start bit at mid-bit. It then samples each data bit at mid-bit, least significant bit first. At the middle of the stop bit it places the character in Z.

A completed character raises an event flag. The flag stays up until software pulses the acknowledge input. The pad-control field also governs the pad driver in receive mode. When that field selects the driver, the pad is forced to its idle-high level, so the receiver never sees a start edge. Receiving therefore requires that field to leave the pad as an input.

Top module: `pin_async_rx`

## Requirements
- R1: The engine is active only when the mode selector equals 5'b11111. Under any other value no character is received, the event flag stays 0 and Z reads 0.
- R2: X bits [31:16] give the bit period in clock cycles, and values below 2 act as 2. X bits [4:0] give the character length minus one, so the length runs from 1 to 32 bits.
- R3: A frame begins on a high-to-low transition of the line. The line is sampled again half a bit period later. If it is high there, the frame is dropped and no event is raised.
- R4: Data bits are sampled once per bit period at mid-bit, and the first bit received is bit 0 of the character.
- R5: The received character is right-justified in Z, and every bit above the character length reads 0.
- R6: Completing a character sets the event flag. The flag stays 1 until a cycle with ack high, and it reads 0 from the next cycle on. If a character completes in the same cycle as ack, the flag stays set.
- R7: A character that completes while the flag is still set replaces Z, and the flag remains 1.
- R8: Pad-control value 2'b01 drives the pad (pad_oe=1, pad_out=1), and the receiver sees the driven level, so no character is received. Value 2'b00 gives pad_oe=0 and normal reception.
- R9: After reset the event flag is 0, Z is 0, pad_oe is 0 and the engine is inactive.
- R10: Z changes only when a character completes or the engine is switched off. An acknowledge leaves Z unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_sel | input | 5 | Function selector; 5'b11111 selects receive |
| pad_ctl | input | 2 | Pad-control field; 2'b01 enables the driver |
| x_wr | input | 1 | Write strobe for the X register |
| x_val | input | 32 | Bit period in [31:16], length minus one in [4:0] |
| ack | input | 1 | Acknowledge strobe that clears the event flag |
| pad_in | input | 1 | Level arriving at the pad |
| pad_oe | output | 1 | Pad driver enable |
| pad_out | output | 1 | Level driven when pad_oe is high |
| event_flag | output | 1 | Character-received flag |
| z_val | output | 32 | Last received character, right-justified |

## Verification
The bench sweeps every 8-bit value, every character length from 1 to 32 and a range of bit periods down to the minimum. A design that sampled off-centre, reversed the bit order or left stale upper bits in Z would return wrong values in these sweeps. A single-cycle low pulse is sent to probe the start recheck; a design without it would report a spurious all-ones character. Further checks cover a second character sent before the acknowledge, a driven pad and a non-receive mode. A design that lost the flag on overwrite, still received through a driven pad or ignored the mode code would show an event, or a missing one, where none is expected.

// File: rtl/pin_rx_pkg.sv
package pin_rx_pkg;
  parameter int RX_DATA_W = 32;
  parameter int RX_PER_W  = 16;
  parameter int RX_LEN_W  = 5;
  localparam logic [4:0] RX_MODE_CODE = 5'b11111;
  localparam logic [1:0] PAD_DRIVE    = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_t;

  function automatic logic [RX_PER_W-1:0] eff_period(input logic [RX_PER_W-1:0] p);
    return (p < 2) ? RX_PER_W'(2) : p;
  endfunction

  function automatic logic [RX_PER_W-1:0] half_period(input logic [RX_PER_W-1:0] p);
    return eff_period(p) >> 1;
  endfunction

  function automatic logic [RX_DATA_W-1:0] justify(input logic [RX_DATA_W-1:0] sh,
                                                    input logic [RX_LEN_W-1:0] len_m1);
    int unsigned amt;
    amt = RX_DATA_W - 1 - int'(len_m1);
    return sh >> amt;
  endfunction
endpackage

// File: rtl/rx_line_edge.sv
module rx_line_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_seen,
  output logic line_q,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      line_q <= line_seen;
      prev_q <= line_q;
    end
  end

  assign fall = prev_q & ~line_q;
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import pin_rx_pkg::*;
#(
  parameter int DATA_W = RX_DATA_W,
  parameter int PER_W  = RX_PER_W,
  parameter int LEN_W  = RX_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              line_q,
  input  logic              fall,
  input  logic [PER_W-1:0]  period,
  input  logic [LEN_W-1:0]  len_m1,
  output logic              done,
  output logic [DATA_W-1:0] char_o
);
  rx_state_t          state;
  logic [PER_W-1:0]   cnt;
  logic [LEN_W-1:0]   bit_idx;
  logic [DATA_W-1:0]  sh;
  logic               at_mid;

  assign at_mid = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      sh      <= '0;
    end else if (!enable) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (fall) begin
          state <= ST_START;
          cnt   <= half_period(period) - 1'b1;
        end
        ST_START: if (at_mid) begin
          if (line_q) state <= ST_IDLE;
          else begin
            state   <= ST_DATA;
            cnt     <= eff_period(period) - 1'b1;
            bit_idx <= '0;
          end
        end else cnt <= cnt - 1'b1;
        ST_DATA: if (at_mid) begin
          sh  <= {line_q, sh[DATA_W-1:1]};
          cnt <= eff_period(period) - 1'b1;
          if (bit_idx == len_m1) state <= ST_STOP;
          else bit_idx <= bit_idx + 1'b1;
        end else cnt <= cnt - 1'b1;
        ST_STOP: if (at_mid) state <= ST_IDLE;
        else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done   = enable && (state == ST_STOP) && at_mid;
  assign char_o = justify(sh, len_m1);

  assert_glitch_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_START && at_mid && line_q) |=> (state == ST_IDLE));
  assert_off_goes_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == ST_IDLE && !done));
endmodule

// File: rtl/rx_result_hold.sv
module rx_result_hold #(
  parameter int DATA_W = pin_rx_pkg::RX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              done,
  input  logic [DATA_W-1:0] char_i,
  input  logic              ack,
  output logic              flag,
  output logic [DATA_W-1:0] z
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      z    <= '0;
    end else if (!enable) begin
      flag <= 1'b0;
      z    <= '0;
    end else if (done) begin
      flag <= 1'b1;
      z    <= char_i;
    end else if (ack) begin
      flag <= 1'b0;
    end
  end

  assert_flag_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && flag && !ack) |=> flag);
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done) |=> !flag);
  assert_z_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !done) |=> $stable(z));
  assert_off_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!flag && z == '0));
endmodule

// File: rtl/pin_async_rx.sv
module pin_async_rx
  import pin_rx_pkg::*;
#(
  parameter int DATA_W = RX_DATA_W,
  parameter int PER_W  = RX_PER_W,
  parameter int LEN_W  = RX_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [4:0]        mode_sel,
  input  logic [1:0]        pad_ctl,
  input  logic              x_wr,
  input  logic [31:0]       x_val,
  input  logic              ack,
  input  logic              pad_in,
  output logic              pad_oe,
  output logic              pad_out,
  output logic              event_flag,
  output logic [DATA_W-1:0] z_val
);
  localparam int PER_LSB = 16;

  logic [4:0]        mode_q;
  logic [1:0]        ctl_q;
  logic [31:0]       x_q;
  logic              mode_rx;
  logic              line_seen, line_q, fall, done;
  logic [DATA_W-1:0] char_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctl_q  <= '0;
      x_q    <= '0;
    end else begin
      if (mode_wr) begin
        mode_q <= mode_sel;
        ctl_q  <= pad_ctl;
      end
      if (x_wr) x_q <= x_val;
    end
  end

  assign mode_rx   = (mode_q == RX_MODE_CODE);
  assign pad_oe    = (ctl_q == PAD_DRIVE);
  assign pad_out   = 1'b1;
  assign line_seen = pad_oe ? pad_out : pad_in;

  rx_line_edge i_edge (
    .clk(clk), .rst_n(rst_n), .line_seen(line_seen), .line_q(line_q), .fall(fall)
  );

  rx_frame_engine #(.DATA_W(DATA_W), .PER_W(PER_W), .LEN_W(LEN_W)) i_engine (
    .clk(clk), .rst_n(rst_n), .enable(mode_rx), .line_q(line_q), .fall(fall),
    .period(x_q[PER_LSB +: PER_W]), .len_m1(x_q[LEN_W-1:0]),
    .done(done), .char_o(char_w)
  );

  rx_result_hold #(.DATA_W(DATA_W)) i_hold (
    .clk(clk), .rst_n(rst_n), .enable(mode_rx), .done(done), .char_i(char_w),
    .ack(ack), .flag(event_flag), .z(z_val)
  );

  assert_drive_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && $past(pad_oe)) |-> !fall);
  assert_overwrite_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && event_flag) |=> event_flag);
endmodule

// File: tb/test_pin_async_rx.sv
module test_pin_async_rx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [4:0]  mode_sel = '0;
  logic [1:0]  pad_ctl = '0;
  logic        x_wr = 1'b0;
  logic [31:0] x_val = '0;
  logic        ack = 1'b0;
  logic        pad_in = 1'b1;
  logic        pad_oe, pad_out, event_flag;
  logic [31:0] z_val;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_async_rx i_pin_async_rx (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel), .pad_ctl(pad_ctl),
    .x_wr(x_wr), .x_val(x_val), .ack(ack), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .event_flag(event_flag), .z_val(z_val)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m, input logic [1:0] c);
    @(negedge clk); mode_sel = m; pad_ctl = c; mode_wr = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic set_x(input int per, input int len);
    @(negedge clk); x_val = (32'(per) << 16) | 32'(len - 1); x_wr = 1'b1;
    @(negedge clk); x_wr = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic send(input logic [31:0] data, input int len, input int per);
    @(negedge clk);
    pad_in = 1'b0; repeat (per) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      pad_in = data[i]; repeat (per) @(negedge clk);
    end
    pad_in = 1'b1; repeat (per + 6) @(negedge clk);
  endtask

  function automatic logic [31:0] masked(input logic [31:0] d, input int len);
    logic [63:0] m;
    m = (64'd1 << len) - 64'd1;
    return d & m[31:0];
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 flag", 32'(event_flag), 0);
    check("R9 z", z_val, 0);
    check("R9 oe", 32'(pad_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 non-receive mode ignores a frame
    set_x(4, 8);
    set_mode(5'b11110, 2'b00);
    send(32'h5A, 8, 4);
    check("R1 flag off-mode", 32'(event_flag), 0);
    check("R1 z off-mode", z_val, 0);

    // R4 R5 R6 sweep of all 8-bit values
    set_mode(5'b11111, 2'b00);
    check("R8 oe input", 32'(pad_oe), 0);
    for (int v = 0; v < 256; v++) begin
      send(32'(v), 8, 4);
      check("R6 flag set", 32'(event_flag), 1);
      check("R4 R5 byte", z_val, 32'(v));
      pulse_ack();
      check("R6 flag cleared", 32'(event_flag), 0);
      check("R10 z after ack", z_val, 32'(v));
    end

    // R2 R5 every length
    for (int len = 1; len <= 32; len++) begin
      set_x(3, len);
      send(32'hA5C396E1, len, 3);
      check("R5 len pattern", z_val, masked(32'hA5C396E1, len));
      pulse_ack();
      send(32'h5A3C691E, len, 3);
      check("R5 len pattern2", z_val, masked(32'h5A3C691E, len));
      pulse_ack();
    end

    // R2 periods including values below 2
    for (int per = 0; per <= 9; per++) begin
      set_x(per, 5);
      send(32'h15 ^ 32'(per), 5, (per < 2) ? 2 : per);
      check("R2 period", z_val, masked(32'h15 ^ 32'(per), 5));
      check("R2 flag", 32'(event_flag), 1);
      pulse_ack();
    end

    // R3 glitch on the line
    set_x(8, 8);
    @(negedge clk); pad_in = 1'b0;
    @(negedge clk); pad_in = 1'b1;
    repeat (120) @(negedge clk);
    check("R3 glitch no flag", 32'(event_flag), 0);
    check("R3 glitch z", z_val, masked(32'h15 ^ 32'd9, 5));
    send(32'hC4, 8, 8);
    check("R3 after glitch", z_val, 32'hC4);
    check("R3 flag", 32'(event_flag), 1);

    // R7 overwrite without ack
    send(32'h3B, 8, 8);
    check("R7 z overwrite", z_val, 32'h3B);
    check("R7 flag kept", 32'(event_flag), 1);
    pulse_ack();

    // R8 driven pad blocks reception
    set_mode(5'b11111, 2'b01);
    check("R8 oe driven", 32'(pad_oe), 1);
    check("R8 out level", 32'(pad_out), 1);
    send(32'h00, 8, 8);
    check("R8 no flag", 32'(event_flag), 0);
    check("R8 z kept", z_val, 32'h3B);
    set_mode(5'b11111, 2'b00);
    send(32'h81, 8, 8);
    check("R8 input again", z_val, 32'h81);

    // R1 leaving receive mode clears state
    set_mode(5'b00000, 2'b00);
    @(negedge clk);
    check("R1 z cleared", z_val, 0);
    check("R1 flag cleared", 32'(event_flag), 0);

    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule